// File: doc/BRIEF.md
# Coincident Event Serializer

This block sits between bus-decoding logic and a formal property monitor. The decoder can raise several event flags in one cycle. The monitor, however, accepts only one event per cycle, and the order of those events decides the verdict. The serializer takes each multi-hot event vector and replays its set bits one per clock cycle as a one-hot stream. The lowest index goes first, because the index is the declaration order of the events.

An upstream stage offers a vector by raising `in_valid`. The vector is taken on a rising edge where `in_ready` is high. `in_ready` drops while two or more accepted bits are still waiting. It rises again in the cycle that emits the last waiting bit, so a new vector can follow with no idle cycle. A vector with no bits set is accepted but produces nothing.

Top module: `evt_serializer`

## Requirements
- R1: After a synchronous reset, `out_valid` is 0, `out_event` is all zeros and `in_ready` is 1.
- R2: A vector accepted on a rising edge (`in_valid` and `in_ready` both high) shows its lowest set bit on `out_event` in the cycle that follows that edge.
- R3: `out_event` has at most one bit set. It has exactly one bit set when `out_valid` is 1 and is all zeros when `out_valid` is 0.
- R4: The set bits of an accepted vector leave on consecutive cycles in strictly ascending index order (bit 0 = first declared event). For example, input 0x0009 gives 0x0001 and then 0x0008.
- R5: `in_ready` is 0 exactly while two or more bits of the accepted vector are still waiting to be emitted. Otherwise it is 1.
- R6: A vector offered in the cycle that emits the last waiting bit is accepted at once. Its first bit appears on the very next cycle, with no gap.
- R7: An accepted all-zero vector produces no output: `out_valid` stays 0 in the following cycle.
- R8: `in_valid` with any vector while `in_ready` is 0 has no effect on the output stream.
- R9: A vector with k bits set has emitted all of them within k cycles of its acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Upstream offers `in_events` this cycle |
| in_events | input | N | Coincident event flags, bit i = i-th declared event |
| in_ready | output | 1 | Serializer can take a vector this cycle |
| out_valid | output | 1 | An event is presented on `out_event` |
| out_event | output | N | One-hot event to the monitor |

## Verification
Every output is a combinational view of the waiting-bit register, so each result is due one rising edge after the stimulus that caused it. The bench drives inputs on the falling edge and samples on the next falling edge, after exactly one rising edge has passed. A cycle model in the bench advances on each rising edge from the requirements alone. It predicts `out_event`, `out_valid` and `in_ready` for every sampled cycle. Directed sequences check the literal values of the ordering, back-to-back, ignored-input and zero-vector cases at those same sample points.

// File: rtl/evt_serializer.sv
module evt_serializer #(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [N-1:0] in_events,
  output logic         in_ready,
  output logic         out_valid,
  output logic [N-1:0] out_event
);
  logic [N-1:0] waiting;
  logic [N-1:0] lowest;
  logic         several;

  assign lowest    = waiting & (~waiting + N'(1));
  assign several   = |(waiting & (waiting - N'(1)));
  assign in_ready  = !several;
  assign out_valid = |waiting;
  assign out_event = lowest;

  always_ff @(posedge clk) begin
    if (rst)
      waiting <= '0;
    else if (in_valid && in_ready)
      waiting <= in_events;
    else
      waiting <= waiting & ~lowest;
  end
endmodule

module evt_serializer_chk #(
  parameter int N = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         in_valid,
  input logic [N-1:0] in_events,
  input logic         in_ready,
  input logic         out_valid,
  input logic [N-1:0] out_event
);
  AST_ONE_HOT_OUT: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ($countones(out_event) == 1)); // R3
  AST_QUIET_OUT: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> (out_event == '0)); // R3
  AST_ASCENDING: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !in_ready) |=> (out_valid && (out_event > $past(out_event)))); // R4
  AST_HELD_BUSY: assert property (@(posedge clk) disable iff (rst)
    !in_ready |=> out_valid); // R5
  AST_IDLE_READY: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> in_ready); // R5
  AST_FIRST_OUT: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && (in_events != '0)) |=>
      (out_valid && ((out_event & ($past(in_events) - N'(1))) == '0)
       && ((out_event & $past(in_events)) != '0))); // R2
  AST_ZERO_VEC: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && (in_events == '0)) |=> !out_valid); // R7
endmodule

bind evt_serializer evt_serializer_chk #(.N(N)) u_chk (.*);

// File: tb/evt_serializer_test.sv
module evt_serializer_test;
  localparam int N = 16;
  logic clk = 0, rst = 1, in_valid = 0;
  logic [N-1:0] in_events = '0;
  logic in_ready, out_valid;
  logic [N-1:0] out_event;
  int checks = 0, errors = 0;
  logic [N-1:0] model = '0;
  int since_accept = 0, bits_at_accept = 0;

  always #10 clk = ~clk;

  evt_serializer #(.N(N)) uut (.*);

  function automatic logic [N-1:0] low_of(logic [N-1:0] v);
    for (int i = 0; i < N; i++) if (v[i]) return N'(1) << i;
    return '0;
  endfunction

  function automatic int pop(logic [N-1:0] v);
    int c = 0;
    for (int i = 0; i < N; i++) c += int'(v[i]);
    return c;
  endfunction

  always @(posedge clk) begin
    if (rst) model <= '0;
    else if (in_valid && pop(model) <= 1) begin
      model <= in_events; since_accept <= 0; bits_at_accept <= pop(in_events);
    end else begin
      model <= model & ~low_of(model); since_accept <= since_accept + 1;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_check();
    chk("R3 out_event", 32'(out_event), 32'(low_of(model)));
    chk("R3 out_valid", 32'(out_valid), 32'(model != '0));
    chk("R5 in_ready", 32'(in_ready), 32'(pop(model) <= 1));
    if (since_accept >= bits_at_accept) chk("R9 drained", 32'(model != '0), 0);
  endtask

  task automatic drive(logic v, logic [N-1:0] e);
    in_valid = v; in_events = e;
    @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(1234));
    @(negedge clk); @(negedge clk);
    rst = 0;
    chk("R1 out_valid", 32'(out_valid), 0);
    chk("R1 out_event", 32'(out_event), 0);
    chk("R1 in_ready", 32'(in_ready), 1);

    drive(1, 16'h0009);
    chk("R2 first bit", 32'(out_event), 32'h1);
    chk("R5 busy", 32'(in_ready), 0);
    drive(0, 16'h0000);
    chk("R4 second bit", 32'(out_event), 32'h8);
    chk("R5 ready on last", 32'(in_ready), 1);
    drive(1, 16'h0006);
    chk("R6 no gap", 32'(out_event), 32'h2);
    drive(1, 16'hFFFF);
    chk("R8 ignored", 32'(out_event), 32'h4);
    drive(1, 16'h0000);
    chk("R7 zero vector", 32'(out_valid), 0);
    chk("R7 ready", 32'(in_ready), 1);
    drive(1, 16'h8000);
    chk("R2 top bit", 32'(out_event), 32'h8000);
    drive(1, 16'hFFFF);
    for (int i = 0; i < N; i++) begin
      chk("R4 full sweep", 32'(out_event), 32'(1) << i);
      drive(0, 16'h0000);
    end
    chk("R9 full drained", 32'(out_valid), 0);

    for (int n = 0; n < 4000; n++) begin
      logic [N-1:0] ev;
      ev = N'($urandom);
      if ($urandom % 3 == 0) ev = ev & N'($urandom);
      if ($urandom % 8 == 0) ev = '0;
      drive(($urandom % 4) != 0, ev);
      model_check();
    end

    rst = 1;
    drive(1, 16'h00F0);
    rst = 0;
    chk("R1 reset out_valid", 32'(out_valid), 0);
    chk("R1 reset in_ready", 32'(in_ready), 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule